// File: doc/BRIEF.md
# Set/Reset/Load Register Cell

A parameterised-width register that captures on the rising clock edge. It has a full set of control inputs. Two active-low asynchronous controls act without waiting for a clock: one forces every bit to zero and the other forces every bit to one. On each rising edge, a synchronous clear and a synchronous fill decide the next value first. Only when neither is active does a load enable choose between taking new data and keeping the stored word.

A compile-time parameter decides what happens when the synchronous clear and the synchronous fill arrive in the same cycle. In fill-wins mode the next state is `fill OR (NOT clear AND loaded)`. In clear-wins mode it is `NOT clear AND (loaded OR fill)`. Here `loaded` is the load-enable multiplexer output: `d` when `ld` is high, the current `q` when it is low. The cell drives the stored word and its bitwise complement, and both come from registers. It is meant as a leaf storage element inside control and datapath logic that needs both power-on style forcing and cycle-accurate clear and fill.

Top module: `srl_cell`

## Requirements
- R1: While `clr_n` is 0, `q` is all zeros and `q_n` is all ones. This takes effect as soon as `clr_n` falls, with no clock edge needed.
- R2: While `pre_n` is 0 and `clr_n` is 1, `q` is all ones and `q_n` is all zeros. This takes effect as soon as `pre_n` falls.
- R3: When `clr_n` and `pre_n` are both 0, `q` is all zeros: the clear wins.
- R4: While either asynchronous control is asserted, rising edges leave `q` at the forced value, whatever `srst`, `sset`, `ld` and `d` are.
- R5: A rising edge with `srst`=1 and `sset`=0 makes `q` all zeros, whatever `ld` and `d` are.
- R6: A rising edge with `sset`=1 and `srst`=0 makes `q` all ones, whatever `ld` and `d` are.
- R7: A rising edge with `srst`=1 and `sset`=1 makes `q` all ones when `SET_WINS`=1 and all zeros when `SET_WINS`=0.
- R8: A rising edge with `ld`=1, `srst`=0 and `sset`=0 copies `d` into `q`.
- R9: A rising edge with `ld`=0, `srst`=0 and `sset`=0 leaves `q` unchanged, whatever `d` is.
- R10: Between rising edges, `q` does not change when `srst`, `sset`, `ld` or `d` change.
- R11: Outside asynchronous forcing, `q_n` is the bitwise complement of `q` after every edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear to all zeros, active low, highest priority |
| pre_n | input | 1 | Asynchronous preset to all ones, active low |
| srst | input | 1 | Synchronous clear, active high |
| sset | input | 1 | Synchronous fill with ones, active high |
| ld | input | 1 | Load enable: 1 takes `d`, 0 holds |
| d | input | WIDTH | Data to load |
| q | output | WIDTH | Stored word |
| q_n | output | WIDTH | Bitwise complement of the stored word |

## Verification
The interesting collision is the synchronous clear and the synchronous fill landing on the same rising edge, often with the load enable also active. The bench drives every combination of `srst`, `sset` and `ld`, together with every data word and every starting value of a 4-bit cell. Two instances run side by side, one per dominance setting, and the result of each collision is judged against all ones or all zeros according to that instance's mode. A second collision, the two asynchronous controls asserted together, is provoked while clocks keep running with synchronous controls active, and must leave the word cleared.

// File: rtl/srl_pkg.sv
package srl_pkg;

  // Resolution of simultaneous synchronous clear and fill
  typedef enum logic {
    DOM_CLEAR = 1'b0,
    DOM_FILL  = 1'b1
  } dom_e;

  function automatic dom_e dom_from_bit(input bit set_wins);
    return set_wins ? DOM_FILL : DOM_CLEAR;
  endfunction

endpackage

// File: rtl/srl_next_state.sv
module srl_next_state
  import srl_pkg::*;
#(
  parameter int   WIDTH = 8,
  parameter dom_e DOM   = DOM_FILL
) (
  input  logic [WIDTH-1:0] q_cur,
  input  logic [WIDTH-1:0] d,
  input  logic             ld,
  input  logic             srst,
  input  logic             sset,
  output logic [WIDTH-1:0] nxt
);

  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] loaded;
  logic [WIDTH-1:0] clr_mask;
  logic [WIDTH-1:0] fill_mask;

  // Load-enable multiplexer sits below the synchronous controls
  always_comb begin
    loaded    = ld ? d : q_cur;
    clr_mask  = srst ? '0 : ONES;
    fill_mask = sset ? ONES : '0;
  end

  generate
    if (DOM == DOM_FILL) begin : g_fill_wins
      always_comb nxt = fill_mask | (clr_mask & loaded);
    end else begin : g_clear_wins
      always_comb nxt = clr_mask & (loaded | fill_mask);
    end
  endgenerate

endmodule

// File: rtl/srl_bit.sv
module srl_bit (
  input  logic clk,
  input  logic clr_n,
  input  logic pre_n,
  input  logic nxt,
  output logic q,
  output logic q_n
);

  // Both outputs are stored, so neither is an inverter behind the other
  always_ff @(posedge clk or negedge clr_n or negedge pre_n) begin
    if (!clr_n) begin
      q   <= 1'b0;
      q_n <= 1'b1;
    end else if (!pre_n) begin
      q   <= 1'b1;
      q_n <= 1'b0;
    end else begin
      q   <= nxt;
      q_n <= ~nxt;
    end
  end

  p_clear_forces_r1: assert property (@(posedge clk)
    !clr_n |-> (q == 1'b0 && q_n == 1'b1));

  p_preset_forces_r2: assert property (@(posedge clk)
    (clr_n && !pre_n) |-> (q == 1'b1 && q_n == 1'b0));

  p_clear_beats_preset_r3: assert property (@(posedge clk)
    (!clr_n && !pre_n) |-> (q == 1'b0));

  p_complement_r11: assert property (@(posedge clk) disable iff (!clr_n || !pre_n)
    q_n == ~q);

endmodule

// File: rtl/srl_cell.sv
module srl_cell
  import srl_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter bit SET_WINS = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             pre_n,
  input  logic             srst,
  input  logic             sset,
  input  logic             ld,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic [WIDTH-1:0] q_n
);

  localparam dom_e             DOM  = dom_from_bit(SET_WINS);
  localparam logic [WIDTH-1:0] ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] nxt;

  srl_next_state #(
    .WIDTH (WIDTH),
    .DOM   (DOM)
  ) u_next (
    .q_cur (q),
    .d     (d),
    .ld    (ld),
    .srst  (srst),
    .sset  (sset),
    .nxt   (nxt)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    srl_bit u_bit (
      .clk   (clk),
      .clr_n (clr_n),
      .pre_n (pre_n),
      .nxt   (nxt[i]),
      .q     (q[i]),
      .q_n   (q_n[i])
    );
  end

  // Checks on synchronous behaviour; a forcing control in the
  // following cycle excuses the consequent.
  logic async_idle;
  assign async_idle = clr_n && pre_n;

  p_sync_clear_r5: assert property (@(posedge clk) disable iff (!clr_n || !pre_n)
    (async_idle && srst && !sset) |=> (!async_idle || q == '0));

  p_sync_fill_r6: assert property (@(posedge clk) disable iff (!clr_n || !pre_n)
    (async_idle && sset && !srst) |=> (!async_idle || q == ONES));

  generate
    if (DOM == DOM_FILL) begin : g_chk_fill
      p_both_fill_wins_r7: assert property (@(posedge clk) disable iff (!clr_n || !pre_n)
        (async_idle && sset && srst) |=> (!async_idle || q == ONES));
    end else begin : g_chk_clear
      p_both_clear_wins_r7: assert property (@(posedge clk) disable iff (!clr_n || !pre_n)
        (async_idle && sset && srst) |=> (!async_idle || q == '0));
    end
  endgenerate

  p_load_takes_d_r8: assert property (@(posedge clk) disable iff (!clr_n || !pre_n)
    (async_idle && ld && !srst && !sset) |=> (!async_idle || q == $past(d)));

  p_hold_keeps_q_r9: assert property (@(posedge clk) disable iff (!clr_n || !pre_n)
    (async_idle && !ld && !srst && !sset) |=> (!async_idle || q == $past(q)));

endmodule

// File: tb/tb_srl_cell.sv
`timescale 1ns/100ps
module tb_srl_cell;

  localparam int W = 4;
  localparam logic [W-1:0] ALL1 = {W{1'b1}};

  logic clk = 1'b0;
  logic clr_n, pre_n, srst, sset, ld;
  logic [W-1:0] d;
  logic [W-1:0] q_sw, qn_sw, q_cw, qn_cw;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  srl_cell #(.WIDTH(W), .SET_WINS(1'b1)) dut (
    .clk(clk), .clr_n(clr_n), .pre_n(pre_n), .srst(srst), .sset(sset),
    .ld(ld), .d(d), .q(q_sw), .q_n(qn_sw)
  );

  srl_cell #(.WIDTH(W), .SET_WINS(1'b0)) dut_cw (
    .clk(clk), .clr_n(clr_n), .pre_n(pre_n), .srst(srst), .sset(sset),
    .ld(ld), .d(d), .q(q_cw), .q_n(qn_cw)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_both(input string req, input logic [W-1:0] e_sw, input logic [W-1:0] e_cw);
    check(req, q_sw, e_sw);
    check(req, q_cw, e_cw);
    check({req, "/R11 q_n"}, qn_sw, ~e_sw);
    check({req, "/R11 q_n"}, qn_cw, ~e_cw);
  endtask

  initial begin
    #150000;
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    clr_n = 1'b1; pre_n = 1'b1; srst = 1'b0; sset = 1'b0; ld = 1'b0; d = '0;
    // R1: clear acts with no clock edge
    #1 clr_n = 1'b0;
    #0.5 check_both("R1 async clear", '0, '0);
    // R4: sync inputs ignored under clear
    @(negedge clk); sset = 1'b1; ld = 1'b1; d = 4'hA;
    @(posedge clk); #1 check_both("R4 clear holds", '0, '0);
    @(negedge clk); srst = 1'b1;
    @(posedge clk); #1 check_both("R4 clear holds", '0, '0);
    @(negedge clk); clr_n = 1'b1; srst = 1'b0; sset = 1'b0; ld = 1'b0;

    // Exhaustive synchronous sweep
    for (int s0 = 0; s0 < (1 << W); s0++) begin
      for (int c = 0; c < 8; c++) begin
        for (int dv = 0; dv < (1 << W); dv++) begin
          logic [W-1:0] st, e_sw, e_cw;
          logic r, s, l;
          string tag;
          st = W'(s0);
          r = c[2]; s = c[1]; l = c[0];
          @(negedge clk); srst = 1'b0; sset = 1'b0; ld = 1'b1; d = st;
          @(posedge clk); #1 check_both("R8 preload", st, st);
          @(negedge clk); srst = r; sset = s; ld = l; d = W'(dv);
          #1 check_both("R10 no change between edges", st, st);
          if (r && s) begin
            e_sw = ALL1; e_cw = '0; tag = "R7 clear+fill";
          end else if (r) begin
            e_sw = '0; e_cw = '0; tag = "R5 sync clear";
          end else if (s) begin
            e_sw = ALL1; e_cw = ALL1; tag = "R6 sync fill";
          end else if (l) begin
            e_sw = W'(dv); e_cw = W'(dv); tag = "R8 load";
          end else begin
            e_sw = st; e_cw = st; tag = "R9 hold";
          end
          @(posedge clk); #1 check_both(tag, e_sw, e_cw);
        end
      end
    end

    // R2: preset acts at once, R4: survives edges with sync clear
    @(negedge clk); srst = 1'b1; sset = 1'b0; ld = 1'b1; d = 4'h5;
    #0.5 pre_n = 1'b0;
    #0.5 check_both("R2 async preset", ALL1, ALL1);
    @(posedge clk); #1 check_both("R4 preset holds", ALL1, ALL1);
    // R3: both asserted, clear wins
    @(negedge clk); clr_n = 1'b0; srst = 1'b0; sset = 1'b1;
    #1 check_both("R3 clear beats preset", '0, '0);
    @(posedge clk); #1 check_both("R3 clear beats preset", '0, '0);
    @(negedge clk); pre_n = 1'b1;
    @(posedge clk); #1 check_both("R1 clear alone", '0, '0);
    @(negedge clk); clr_n = 1'b1; sset = 1'b0; srst = 1'b0; ld = 1'b1; d = 4'h9;
    @(posedge clk); #1 check_both("R8 load after release", 4'h9, 4'h9);
    repeat (2) @(posedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule